// File: doc/BRIEF.md
# Dual-Line Edge-Select Interrupt Bank

This block collects up to 32 interrupt sources and presents them to two independent interrupt request lines, each serviced by its own bus master. Every source is synchronized into the clock domain and compared with its previous sampled value. A two-bit edge field for each source chooses which transitions count as events: rising, falling, either, or none. An event sets that source's bit in the status register set of both lines.

Each line has its own status bits and its own mask bits, so the two masters can acknowledge and gate sources independently of each other. The edge selection is common to both lines. A line drives its active-low request whenever any of its status bits is set and not masked. One control bit chooses how status is acknowledged. With the bit clear, software writes ones to the status bits it wants cleared. With the bit set, reading a status byte clears the bits in that byte.

A source that fires again while its bit is still pending is remembered. After the first acknowledge the bit stays set, so software may need a second pass to reach an idle state. All registers are reached through a byte-wide read/write port.

Top module: `irq_edge_bank`

## Requirements
- R1: Source i owns bits 2i+1 (rising enable) and 2i (falling enable) of the edge registers, that is byte i/4 at bit offset (i mod 4)*2 at addresses 0..7. The edge registers read back as written.
- R2: An enabled edge on a source sets its status bit in both lines' status sets. The bit becomes visible three clock edges after the input changes: two synchronizer stages plus the status register.
- R3: A source whose two edge bits are both clear never sets status, whatever its input does.
- R4: After reset, every mask bit reads 1 and the status, edge and control registers read 0. Both request lines are high.
- R5: Line l's request irq_n[l] is low exactly when some status bit of line l is set with its mask bit clear. Mask bits are at addresses 12..15 for line 0 and 20..23 for line 1, and a 1 blocks the source.
- R6: With control bit 0 (address 24) clear, writing a byte to a status address (8..11 for line 0, 16..19 for line 1) clears the bits written as 1 and leaves the bits written as 0.
- R7: With control bit 0 set, a read of a status byte returns its current value and then clears all bits of that byte. Writes to status addresses have no effect in this mode.
- R8: An event on a source whose bit is already set in a line is buffered. The next clear of that bit leaves it set, and a following clear then empties it.
- R9: An event that arrives in the same cycle as a clear of that bit keeps the bit set.
- R10: The two lines' status sets are independent: clearing one line leaves the other unchanged. Addresses 25..31 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Asynchronous interrupt source inputs |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe, meaningful for clear-on-read |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| irq_n | output | 2 | Active-low request per line |

## Verification
The hardest states to reach are the buffered second event and an event that lands in the very cycle of a clear. Both need the source edge timed against the bus strobe through the three-stage latency.

The bench reaches the buffered state by toggling a both-edge source twice before acknowledging it. It then shows that one clear leaves the bit set and a second clear empties it. For the same-cycle case it changes a rising-only source and raises the write strobe two edges later, so that the clear and the detected event are applied at the same edge. The buffered bits left in line 1 are then drained through three clear-on-read reads, and each read returns a value fixed in advance.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    localparam int NUM_LINES = 2;
    localparam int IDX_W     = 5;

    typedef enum logic [2:0] {
        RG_EDGE,
        RG_STAT0,
        RG_MASK0,
        RG_STAT1,
        RG_MASK1,
        RG_CTRL,
        RG_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } reg_sel_t;

    // Address map: edge bytes, then status/mask for line 0, then line 1, then control.
    function automatic reg_sel_t decode_addr(input int unsigned a,
                                             input int unsigned eb,
                                             input int unsigned sb);
        reg_sel_t s;
        s.kind = RG_NONE;
        s.idx  = '0;
        if (a < eb) begin
            s.kind = RG_EDGE;
            s.idx  = IDX_W'(a);
        end else if (a < eb + sb) begin
            s.kind = RG_STAT0;
            s.idx  = IDX_W'(a - eb);
        end else if (a < eb + 2*sb) begin
            s.kind = RG_MASK0;
            s.idx  = IDX_W'(a - eb - sb);
        end else if (a < eb + 3*sb) begin
            s.kind = RG_STAT1;
            s.idx  = IDX_W'(a - eb - 2*sb);
        end else if (a < eb + 4*sb) begin
            s.kind = RG_MASK1;
            s.idx  = IDX_W'(a - eb - 3*sb);
        end else if (a == eb + 4*sb) begin
            s.kind = RG_CTRL;
        end
        return s;
    endfunction

endpackage

// File: rtl/irqb_sync_edge.sv
module irqb_sync_edge #(
    parameter int NUM_SRC = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SRC-1:0]     src_in,
    input  logic [2*NUM_SRC-1:0]   edge_cfg,
    output logic [NUM_SRC-1:0]     evt
);
    logic [NUM_SRC-1:0] meta_q;
    logic [NUM_SRC-1:0] sync_q;
    logic [NUM_SRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic up, down;
        assign up     = sync_q[i] & ~prev_q[i];
        assign down   = ~sync_q[i] & prev_q[i];
        assign evt[i] = (up & edge_cfg[2*i+1]) | (down & edge_cfg[2*i]);
    end
endmodule

// File: rtl/irqb_line.sv
module irqb_line #(
    parameter int NUM_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   evt,
    input  logic [NUM_SRC-1:0]   clr,
    input  logic [NUM_SRC-1:0]   mask_we,
    input  logic [NUM_SRC-1:0]   mask_wd,
    output logic [NUM_SRC-1:0]   status,
    output logic [NUM_SRC-1:0]   mask,
    output logic                 irq_n
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] status_n;
    logic [NUM_SRC-1:0] pend_n;

    always_comb begin
        // a clear refills from the buffered event; a fresh event always wins
        status_n = evt | (clr & pend_q) | (~clr & status);
        pend_n   = (clr & evt & pend_q) | (~clr & (pend_q | (evt & status)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            pend_q <= '0;
            mask   <= '1;
        end else begin
            status <= status_n;
            pend_q <= pend_n;
            mask   <= (mask & ~mask_we) | (mask_wd & mask_we);
        end
    end

    assign irq_n = ~|(status & ~mask);
endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank
    import irqb_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    input  logic                 bus_rd,
    output logic [7:0]           bus_rdata,
    output logic [1:0]           irq_n
);
    localparam int SB = NUM_SRC / 8;
    localparam int EB = NUM_SRC / 4;

    reg_sel_t            sel;
    logic [2*NUM_SRC-1:0] edge_q;
    logic                cor_q;
    logic [NUM_SRC-1:0]  evt;
    logic [NUM_SRC-1:0]  stat_v  [NUM_LINES];
    logic [NUM_SRC-1:0]  mask_v  [NUM_LINES];
    logic [NUM_SRC-1:0]  clr_v   [NUM_LINES];
    logic [NUM_SRC-1:0]  mwe_v   [NUM_LINES];
    logic [NUM_SRC-1:0]  mask_wd;

    assign sel     = decode_addr(int'(bus_addr), EB, SB);
    assign mask_wd = {SB{bus_wdata}};

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
            cor_q  <= 1'b0;
        end else if (bus_wr) begin
            for (int e = 0; e < EB; e++) begin
                if (sel.kind == RG_EDGE && int'(sel.idx) == e)
                    edge_q[8*e +: 8] <= bus_wdata;
            end
            if (sel.kind == RG_CTRL)
                cor_q <= bus_wdata[0];
        end
    end

    irqb_sync_edge #(.NUM_SRC(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .edge_cfg (edge_q),
        .evt      (evt)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam reg_kind_e SK = (l == 0) ? RG_STAT0 : RG_STAT1;
        localparam reg_kind_e MK = (l == 0) ? RG_MASK0 : RG_MASK1;

        for (genvar b = 0; b < SB; b++) begin : g_byte
            logic s_hit, m_hit;
            assign s_hit = (sel.kind == SK) && (int'(sel.idx) == b);
            assign m_hit = (sel.kind == MK) && (int'(sel.idx) == b);
            assign clr_v[l][8*b +: 8] = !s_hit ? 8'h00 :
                                        cor_q  ? {8{bus_rd}} :
                                        bus_wr ? bus_wdata : 8'h00;
            assign mwe_v[l][8*b +: 8] = {8{m_hit & bus_wr}};
        end

        irqb_line #(.NUM_SRC(NUM_SRC)) u_line (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt),
            .clr     (clr_v[l]),
            .mask_we (mwe_v[l]),
            .mask_wd (mask_wd),
            .status  (stat_v[l]),
            .mask    (mask_v[l]),
            .irq_n   (irq_n[l])
        );
    end

    always_comb begin
        bus_rdata = 8'h00;
        case (sel.kind)
            RG_EDGE:  bus_rdata = edge_q[8*int'(sel.idx) +: 8];
            RG_STAT0: bus_rdata = stat_v[0][8*int'(sel.idx) +: 8];
            RG_MASK0: bus_rdata = mask_v[0][8*int'(sel.idx) +: 8];
            RG_STAT1: bus_rdata = stat_v[1][8*int'(sel.idx) +: 8];
            RG_MASK1: bus_rdata = mask_v[1][8*int'(sel.idx) +: 8];
            RG_CTRL:  bus_rdata = {7'b0, cor_q};
            default:  bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker #(
    parameter int NUM_SRC = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_SRC-1:0]   evt,
    input logic [2*NUM_SRC-1:0] edge_cfg,
    input logic [NUM_SRC-1:0]   status0,
    input logic [NUM_SRC-1:0]   status1,
    input logic [NUM_SRC-1:0]   mask0,
    input logic [NUM_SRC-1:0]   mask1,
    input logic [1:0]           irq_n
);
    logic [NUM_SRC-1:0] en;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        assign en[i] = edge_cfg[2*i] | edge_cfg[2*i+1];
    end

    // R4: lines idle and masked right after reset
    a_r4_idle_after_reset: assert property (@(posedge clk)
        $past(rst) && !rst |-> irq_n == 2'b11 && status0 == '0 && status1 == '0 && (&mask0) && (&mask1));

    // R3: no event from a source with both edge bits clear
    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (evt & ~en) == '0);

    // R2, R9: every event leaves its bit set in both lines, even against a clear
    a_r2_event_latched: assert property (@(posedge clk) disable iff (rst)
        |evt |=> ((status0 & status1 & $past(evt)) == $past(evt)));

    // R2: a status bit only rises after an event
    a_r2_rise_needs_event: assert property (@(posedge clk) disable iff (rst)
        ((status0 | status1) & ~($past(status0) & $past(status1)) & ~$past(evt)
         & ~($past(status0) ^ $past(status1))) == '0);

    // R5: fully masked lines stay high
    a_r5_masked_line0_high: assert property (@(posedge clk) disable iff (rst)
        (&mask0) |-> irq_n[0]);
    a_r5_masked_line1_high: assert property (@(posedge clk) disable iff (rst)
        (&mask1) |-> irq_n[1]);
endmodule

bind irq_edge_bank irqb_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .edge_cfg (edge_q),
    .status0  (stat_v[0]),
    .status1  (stat_v[1]),
    .mask0    (mask_v[0]),
    .mask1    (mask_v[1]),
    .irq_n    (irq_n)
);

// File: tb/irq_edge_bank_bench.sv
module irq_edge_bank_bench;
    localparam int N = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   src_in = '0;
    logic [4:0]     bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_wdata = '0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_rdata;
    logic [1:0]     irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    irq_edge_bank #(.NUM_SRC(N), .ADDR_W(5)) u_irq_edge_bank (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    // monitor: compare each read against the scoreboard head
    always @(negedge clk) begin
        if (bus_rd && sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                fails++;
                $display("FAIL %s: addr %0d read %h expected %h", it.tag, bus_addr, bus_rdata, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(posedge clk); #1;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic [1:0] e, input string tag);
        @(negedge clk);
        checks++;
        if (irq_n !== e) begin
            fails++;
            $display("FAIL %s: irq_n %b expected %b", tag, irq_n, e);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        summary();
    end

    initial begin
        tick(4);
        rst = 1'b0;
        // R4 reset state
        chk_irq(2'b11, "R4 irq idle");
        rd(5'd0,  8'h00, "R4 edge reset");
        rd(5'd8,  8'h00, "R4 status0 reset");
        rd(5'd12, 8'hFF, "R4 mask0 reset");
        rd(5'd20, 8'hFF, "R4 mask1 reset");
        rd(5'd24, 8'h00, "R4 ctrl reset");
        // R10 unused addresses
        rd(5'd27, 8'h00, "R10 unused 27");
        rd(5'd31, 8'h00, "R10 unused 31");

        // R1: byte1 -> src4 none, src5 both, src6 fall, src7 rise
        wr(5'd1, 8'b10_01_11_00);
        rd(5'd1, 8'b10_01_11_00, "R1 edge readback");

        // R2: rising on src7 reaches both lines
        src_in[7] = 1'b1;
        tick(3);
        rd(5'd8,  8'h80, "R2 line0 rise");
        rd(5'd16, 8'h80, "R2 line1 rise");
        chk_irq(2'b11, "R5 masked no request");
        wr(5'd12, 8'h7F);
        chk_irq(2'b10, "R5 unmasked line0");

        // R1: fall-only source ignores rise, takes fall
        src_in[6] = 1'b1;
        tick(3);
        rd(5'd8, 8'h80, "R1 fall-only ignores rise");
        src_in[6] = 1'b0;
        tick(3);
        rd(5'd8, 8'hC0, "R1 fall-only takes fall");
        src_in[5] = 1'b1;
        tick(3);
        rd(5'd8, 8'hE0, "R1 both-edge rise");
        // R3: disabled source
        src_in[4] = 1'b1; tick(3);
        src_in[4] = 1'b0; tick(3);
        rd(5'd8, 8'hE0, "R3 disabled source quiet");

        // R6 write-one-to-clear
        wr(5'd8, 8'h80);
        rd(5'd8,  8'h60, "R6 w1c clears ones");
        rd(5'd16, 8'hE0, "R10 line1 untouched");
        chk_irq(2'b11, "R5 request drops after clear");
        wr(5'd8, 8'h00);
        rd(5'd8, 8'h60, "R6 zeros leave bits");

        // R8 buffered second event on src5
        src_in[5] = 1'b0;
        tick(3);
        wr(5'd8, 8'h20);
        rd(5'd8, 8'h60, "R8 buffered refill");
        wr(5'd8, 8'h20);
        rd(5'd8, 8'h40, "R8 second clear empties");
        wr(5'd8, 8'h40);
        rd(5'd8, 8'h00, "R8 idle");

        // R9 event coincident with clear on src7
        src_in[7] = 1'b0; tick(3);
        src_in[7] = 1'b1; tick(3);
        rd(5'd8, 8'h80, "R9 setup");
        src_in[7] = 1'b0; tick(3);
        src_in[7] = 1'b1;
        tick(2);
        bus_addr = 5'd8; bus_wdata = 8'h80; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
        rd(5'd8, 8'h80, "R9 new edge wins");
        wr(5'd8, 8'h80);
        rd(5'd8, 8'h00, "R9 clears after");

        // R7 clear-on-read, line1 holds E0 with 7 and 5 buffered
        wr(5'd24, 8'h01);
        rd(5'd24, 8'h01, "R7 ctrl readback");
        wr(5'd16, 8'hFF);
        rd(5'd16, 8'hE0, "R7 write ignored, read clears");
        rd(5'd16, 8'hA0, "R7 R8 buffered after read");
        rd(5'd16, 8'h00, "R7 idle after reads");

        // R5 line1 request independent of line0
        wr(5'd0, 8'h02);
        wr(5'd20, 8'hFE);
        src_in[0] = 1'b1;
        tick(3);
        chk_irq(2'b01, "R5 line1 request only");
        rd(5'd16, 8'h01, "R7 line1 read");
        chk_irq(2'b11, "R5 line1 request after read");
        rd(5'd8, 8'h01, "R10 line0 kept own bit");

        tick(2);
        summary();
    end
endmodule